// File: doc/BRIEF.md
# Dual-Bank Numerically Controlled Oscillator Core

This block is a phase-accumulating sine synthesizer. A 32-bit accumulator advances by a tuning word on every clock, so the output frequency is `word * fclk / 2^32`. The top 12 accumulator bits, plus a selectable 12-bit phase offset, address a quarter-wave sine table. The table result is a registered 10-bit offset-binary sample, ready for a converter.

Two tuning words and four phase offsets are held on chip and loaded through a simple parallel write port. The active word and offset can be switched on a cycle boundary, which gives clean frequency-shift and phase-shift keying. The selection comes either from three asynchronous select pins, each passed through a two-stage synchronizer, or from bits of an internal control word. A flag in the control word picks the source. A sleep bit clears the accumulator and parks the sample at midscale.

Top module: `dds_phase_core`

## Requirements
- R1: On every clock edge that is not in sleep, the accumulator adds the selected tuning word modulo 2^32. `phaseOut` shows accumulator bits [31:20] after that edge.
- R2: Frequency select 0 picks the tuning word written at address 0, and select 1 picks the word written at address 1.
- R3: Phase select n (0..3) picks the offset written at address 2+n. That offset is added modulo 4096 to accumulator bits [31:20] to form the table address p.
- R4: Take the clock edge after the one that sampled address p, when sleep is not set. After it, `sample` equals 512+Q(k) if p[11]=0, and 511-Q(k) if p[11]=1. Here Q(k)=floor(511*sin(pi*(2k+1)/4096)+0.5), k=p[9:0] when p[10]=0, and k=1023-p[9:0] when p[10]=1.
- R5: When the pins are the select source, a change on `fselPin` or `pselPin` is first used by the third clock edge after it is applied.
- R6: The control word is written at address 6. Bit 0 is the frequency select, bits 2:1 are the phase select, bit 3 is the source flag (1 = control bits, 0 = pins) and bit 4 is sleep. With bit 3 set, the pins have no effect.
- R7: While sleep is set, each edge clears the accumulator and sets `sample` to 512. After sleep is cleared, accumulation restarts from zero.
- R8: Reset clears the accumulator, all tuning words, offsets, the control word and the synchronizers, and sets `sample` to 512.
- R9: A write takes effect at the edge where `wrEn` is high and is used from the next edge on. A write to address 7 changes nothing.
- R10: With tuning word 0x5671C71C and the accumulator starting at zero, `phaseOut` after n edges equals bits [31:20] of (n*0x5671C71C mod 2^32). At a 6.25 MHz clock this is about 2.11 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address: 0-1 tuning words, 2-5 phase offsets, 6 control |
| wrData | input | 32 | Write data; offsets use bits 11:0, control uses bits 4:0 |
| fselPin | input | 1 | Asynchronous frequency select pin |
| pselPin | input | 2 | Asynchronous phase select pins |
| sample | output | 10 | Offset-binary sine sample |
| phaseOut | output | 12 | Accumulator bits [31:20] |

## Verification
The bench drives the table address onto every quadrant edge (0, 1023, 1024, 2047, 2048, 3071, 3072, 4095). A design that mirrors or inverts the wrong half would put a sample in the wrong half-range or return the value for the wrong end of a quadrant. The bench also measures pin-to-effect latency edge by edge: a missing or extra synchronizer stage moves the first large step in `phaseOut` by one cycle. Further checks switch the source flag while the pins disagree with the control bits, enter and leave sleep, write to the unused address, and sum the given tuning word over 100 edges. These catch a mux on the wrong source, an accumulator that is frozen rather than cleared, a stray register write, and a carry lost in the 32-bit add.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int NUM_FREQ  = 2;
  localparam int NUM_PHASE = 4;
  localparam int FSEL_W    = $clog2(NUM_FREQ);
  localparam int PSEL_W    = $clog2(NUM_PHASE);
  localparam int ADDR_W    = 3;

  // control word layout
  localparam int CB_FSEL  = 0;
  localparam int CB_PSEL  = CB_FSEL + FSEL_W;
  localparam int CB_SRC   = CB_PSEL + PSEL_W;
  localparam int CB_SLEEP = CB_SRC + 1;
  localparam int CTL_W    = CB_SLEEP + 1;

  localparam real PI_VAL = 3.141592653589793;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic              sleep;
    logic [FSEL_W-1:0] freqSel;
    logic [PSEL_W-1:0] phaseSel;
    logic              freqWr;
    logic              phaseWr;
    logic [PSEL_W-1:0] wrIdx;
  } strobe_t;

  // quarter-wave magnitude for table entry k, sampled at bin centres
  function automatic int quarterAmp(int k, int idxBits, int ampBits);
    real peak;
    real arg;
    peak = real'((1 << (ampBits - 1)) - 1);
    arg  = PI_VAL * real'(2 * k + 1) / real'(1 << (idxBits + 2));
    return $rtoi($floor(peak * $sin(arg) + 0.5));
  endfunction
endpackage

// File: rtl/dds_sine_rom.sv
module dds_sine_rom
  import dds_pkg::*;
#(
  parameter int PHASE_W = 12,
  parameter int AMP_W   = 10
) (
  input  logic [PHASE_W-1:0] phaseAddr,
  output logic [AMP_W-1:0]   amp
);
  localparam int IDX_W = PHASE_W - 2;
  localparam int DEPTH = 1 << IDX_W;
  localparam int MAG_W = AMP_W - 1;

  logic [MAG_W-1:0] quarter [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++) quarter[k] = MAG_W'(quarterAmp(k, IDX_W, AMP_W));
  end

  logic [IDX_W-1:0] idx;
  logic [MAG_W-1:0] mag;

  always_comb begin
    // odd quadrants read the table backwards
    idx = phaseAddr[IDX_W] ? ~phaseAddr[IDX_W-1:0] : phaseAddr[IDX_W-1:0];
    mag = quarter[idx];
    // lower half-cycle inverts around midscale
    amp = phaseAddr[PHASE_W-1] ? {1'b0, ~mag} : {1'b1, mag};
  end
endmodule

// File: rtl/dds_ctrl.sv
module dds_ctrl
  import dds_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CTL_W-1:0]  wrCtl,
  input  logic              fselPin,
  input  logic [PSEL_W-1:0] pselPin,
  output strobe_t           strb
);
  localparam logic [ADDR_W-1:0] FREQ_END  = ADDR_W'(NUM_FREQ);
  localparam logic [ADDR_W-1:0] PHASE_END = ADDR_W'(NUM_FREQ + NUM_PHASE);
  localparam logic [ADDR_W-1:0] CTL_ADDR  = PHASE_END;

  logic [CTL_W-1:0]  ctlReg;
  logic              fSync1, fSync2;
  logic [PSEL_W-1:0] pSync1, pSync2;
  logic              ctlWr;

  assign ctlWr = wrEn && (wrAddr == CTL_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg <= '0;
      fSync1 <= 1'b0;
      fSync2 <= 1'b0;
      pSync1 <= '0;
      pSync2 <= '0;
    end else begin
      fSync1 <= fselPin;
      fSync2 <= fSync1;
      pSync1 <= pselPin;
      pSync2 <= pSync1;
      if (ctlWr) ctlReg <= wrCtl;
    end
  end

  always_comb begin
    strb.freqWr   = wrEn && (wrAddr < FREQ_END);
    strb.phaseWr  = wrEn && (wrAddr >= FREQ_END) && (wrAddr < PHASE_END);
    strb.wrIdx    = strb.freqWr ? PSEL_W'(wrAddr) : PSEL_W'(wrAddr - FREQ_END);
    strb.sleep    = ctlReg[CB_SLEEP];
    strb.freqSel  = ctlReg[CB_SRC] ? ctlReg[CB_FSEL +: FSEL_W] : fSync2;
    strb.phaseSel = ctlReg[CB_SRC] ? ctlReg[CB_PSEL +: PSEL_W] : pSync2;
  end

  // edges since reset, saturating, for the latency checks
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assert_fsel_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && !ctlReg[CB_SRC]) |-> strb.freqSel == $past(fselPin, 2));

  assert_psel_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && !ctlReg[CB_SRC]) |-> strb.phaseSel == $past(pselPin, 2));

  assert_unused_addr_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr > CTL_ADDR) |=> $stable(ctlReg));
endmodule

// File: rtl/dds_datapath.sv
module dds_datapath
  import dds_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 12,
  parameter int AMP_W   = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [ACC_W-1:0]   wrData,
  output logic [AMP_W-1:0]   sample,
  output logic [PHASE_W-1:0] phaseOut
);
  localparam logic [AMP_W-1:0] MID = AMP_W'(1 << (AMP_W - 1));

  logic [ACC_W-1:0]   freqBank  [NUM_FREQ];
  logic [PHASE_W-1:0] phaseBank [NUM_PHASE];
  logic [ACC_W-1:0]   acc;
  logic [PHASE_W-1:0] phaseAddr;
  logic [AMP_W-1:0]   romAmp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_FREQ; i++)  freqBank[i]  <= '0;
      for (int i = 0; i < NUM_PHASE; i++) phaseBank[i] <= '0;
    end else begin
      if (strb.freqWr)  freqBank[strb.wrIdx[FSEL_W-1:0]] <= wrData;
      if (strb.phaseWr) phaseBank[strb.wrIdx] <= wrData[PHASE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           acc <= '0;
    else if (strb.sleep) acc <= '0;
    else                 acc <= acc + freqBank[strb.freqSel];
  end

  assign phaseAddr = acc[ACC_W-1 -: PHASE_W] + phaseBank[strb.phaseSel];

  dds_sine_rom #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_rom (
    .phaseAddr(phaseAddr),
    .amp      (romAmp)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           sample <= MID;
    else if (strb.sleep) sample <= MID;
    else                 sample <= romAmp;
  end

  assign phaseOut = acc[ACC_W-1 -: PHASE_W];

  assert_sleep_clears_acc_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.sleep) |-> acc == '0);

  assert_sleep_midscale_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.sleep) |-> sample == MID);

  assert_half_cycle_sign_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.sleep) |-> sample[AMP_W-1] == ~$past(phaseAddr[PHASE_W-1]));
endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core
  import dds_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 12,
  parameter int AMP_W   = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [ACC_W-1:0]   wrData,
  input  logic               fselPin,
  input  logic [PSEL_W-1:0]  pselPin,
  output logic [AMP_W-1:0]   sample,
  output logic [PHASE_W-1:0] phaseOut
);
  strobe_t strb;

  dds_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrCtl  (wrData[CTL_W-1:0]),
    .fselPin(fselPin),
    .pselPin(pselPin),
    .strb   (strb)
  );

  dds_datapath #(.ACC_W(ACC_W), .PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .sample  (sample),
    .phaseOut(phaseOut)
  );
endmodule

// File: tb/sim_dds_phase_core.sv
module sim_dds_phase_core;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        fselPin = 1'b0;
  logic [1:0]  pselPin = '0;
  logic [9:0]  sample;
  logic [11:0] phaseOut;

  always #2 clk = ~clk;

  dds_phase_core u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .fselPin(fselPin), .pselPin(pselPin), .sample(sample), .phaseOut(phaseOut)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // behavioural expectation built from the requirements
  logic [31:0] mAcc;
  logic [31:0] mFreq [2];
  logic [11:0] mPhase [4];
  logic [4:0]  mCtl;
  logic        mF1, mF2;
  logic [1:0]  mP1, mP2;
  logic [9:0]  mSample;

  function automatic int refQ(int k);
    return $rtoi($floor(511.0 * $sin(3.141592653589793 * real'(2 * k + 1) / 4096.0) + 0.5));
  endfunction

  function automatic logic [9:0] refSine(logic [11:0] p);
    int k;
    k = int'(p[9:0]);
    if (p[10]) k = 1023 - k;
    return p[11] ? 10'(511 - refQ(k)) : 10'(512 + refQ(k));
  endfunction

  task automatic modelEdge();
    logic       fs;
    logic [1:0] ps;
    logic [11:0] addr;
    fs = mCtl[3] ? mCtl[0] : mF2;
    ps = mCtl[3] ? mCtl[2:1] : mP2;
    if (mCtl[4]) begin
      mSample = 10'd512;
      mAcc    = '0;
    end else begin
      addr    = mAcc[31:20] + mPhase[ps];
      mSample = refSine(addr);
      mAcc    = mAcc + mFreq[fs];
    end
    mF2 = mF1; mP2 = mP1;
    mF1 = fselPin; mP1 = pselPin;
    if (wrEn) begin
      case (wrAddr)
        3'd0, 3'd1:             mFreq[wrAddr[0]] = wrData;
        3'd2, 3'd3, 3'd4, 3'd5: mPhase[2'(wrAddr - 3'd2)] = wrData[11:0];
        3'd6:                   mCtl = wrData[4:0];
        default: ;
      endcase
    end
  endtask

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(string req);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check(req, "sample", int'(sample), int'(mSample));
    check(req, "phaseOut", int'(phaseOut), int'(mAcc[31:20]));
  endtask

  task automatic writeReg(string req, logic [2:0] a, logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step(req);
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  typedef struct packed {
    logic [4:0] ctl;
    logic       fpin;
    logic [1:0] ppin;
    logic [7:0] cycles;
    logic [3:0] req;
  } vec_t;

  // control bits: 0 fsel, 2:1 psel, 3 source flag, 4 sleep
  localparam vec_t VECS [8] = '{
    '{5'h00, 1'b0, 2'd0, 8'd6, 4'd1},  // R1 pins, word 0
    '{5'h00, 1'b1, 2'd0, 8'd6, 4'd2},  // R2 pins, word 1
    '{5'h00, 1'b1, 2'd2, 8'd6, 4'd3},  // R3 offset 2
    '{5'h00, 1'b0, 2'd3, 8'd6, 4'd3},  // R3 offset 3, wraps
    '{5'h0B, 1'b0, 2'd0, 8'd6, 4'd6},  // R6 register selects word 1 / offset 1
    '{5'h08, 1'b1, 2'd3, 8'd6, 4'd6},  // R6 pins disagree, ignored
    '{5'h10, 1'b0, 2'd0, 8'd5, 4'd7},  // R7 sleep
    '{5'h00, 1'b0, 2'd0, 8'd6, 4'd7}   // R7 resume from zero
  };

  localparam int EDGES [8] = '{0, 1023, 1024, 2047, 2048, 3071, 3072, 4095};

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    mAcc = '0; mCtl = '0; mF1 = 0; mF2 = 0; mP1 = '0; mP2 = '0; mSample = 10'd512;
    for (int i = 0; i < 2; i++) mFreq[i] = '0;
    for (int i = 0; i < 4; i++) mPhase[i] = '0;

    repeat (3) @(negedge clk);
    check("R8", "reset sample", int'(sample), 512);
    check("R8", "reset phaseOut", int'(phaseOut), 0);
    rstN = 1'b1;
    step("R8");

    // R9 loads, R10 word in bank 0
    writeReg("R9", 3'd0, 32'h5671C71C);
    writeReg("R9", 3'd1, 32'h01000000);
    writeReg("R9", 3'd2, 32'h0);
    writeReg("R9", 3'd3, 32'h155);
    writeReg("R9", 3'd4, 32'h800);
    writeReg("R9", 3'd5, 32'hFFF);

    foreach (VECS[v]) begin
      string tag;
      tag = $sformatf("R%0d", VECS[v].req);
      fselPin = VECS[v].fpin;
      pselPin = VECS[v].ppin;
      writeReg(tag, 3'd6, {27'd0, VECS[v].ctl});
      for (int c = 0; c < int'(VECS[v].cycles); c++) step(tag);
    end

    // R5 latency: word 0 steps phaseOut by 1, word 1 by 5
    writeReg("R5", 3'd0, 32'h00100000);
    writeReg("R5", 3'd1, 32'h00500000);
    fselPin = 1'b0; pselPin = '0;
    repeat (3) step("R5");
    begin
      logic [11:0] p0;
      p0 = phaseOut;
      fselPin = 1'b1;
      step("R5"); check("R5", "edge1 delta", int'(phaseOut), int'(12'(p0 + 12'd1)));
      step("R5"); check("R5", "edge2 delta", int'(phaseOut), int'(12'(p0 + 12'd2)));
      step("R5"); check("R5", "edge3 delta", int'(phaseOut), int'(12'(p0 + 12'd7)));
    end

    // R4 quadrant edges with accumulator parked at zero
    writeReg("R4", 3'd6, 32'h10);
    writeReg("R4", 3'd0, 32'h0);
    writeReg("R4", 3'd6, 32'h08);
    foreach (EDGES[e]) begin
      writeReg("R4", 3'd2, 32'(EDGES[e]));
      step("R4");
      check("R4", $sformatf("addr %0d", EDGES[e]), int'(sample), int'(refSine(12'(EDGES[e]))));
    end

    // R9 unused address
    writeReg("R9", 3'd7, 32'hFFFFFFFF);
    repeat (2) step("R9");
    check("R9", "addr7 sample", int'(sample), int'(refSine(12'd4095)));
    check("R9", "addr7 phaseOut", int'(phaseOut), 0);

    // R10 tuning word summed over 100 edges
    fselPin = 1'b0; pselPin = '0;
    writeReg("R10", 3'd0, 32'h5671C71C);
    writeReg("R10", 3'd2, 32'h0);
    writeReg("R10", 3'd6, 32'h10);
    writeReg("R10", 3'd6, 32'h00);
    repeat (100) step("R10");
    begin
      logic [31:0] prod;
      prod = 32'(64'd100 * 64'h5671C71C);
      check("R10", "phaseOut after 100", int'(phaseOut), int'(prod[31:20]));
    end

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R1 watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule